// File: doc/BRIEF.md
# Interface PHY Power Enable Sequencer

This block drives the power control bits of a group of interface PHYs: a parameterised number of serial-display lanes, one camera-transmit port, one USB port and one HDMI-style port. Each PHY has one request input. When that input differs from the PHY's current power state, the block runs that PHY's fixed enable or disable series. The series steps through its control bits one register update per cycle, so that gates, regulators and resets change in a safe order.

Only one series runs at a time. `busy` is high for the whole series, and `done` pulses for one cycle when the last update lands. A request that changes while a series is running stays pending. The pending PHY with the lowest index is served next. The HDMI-style enable series holds its reset-drive bit through a settling wait. The wait is counted in clock cycles and is derived from the clock frequency and a time in microseconds.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset all lane, camera-transmit, USB and HDMI gate and regulator bits are 0 and `hdmi_ldo_pd` is 1. `busy` and `done` are 0.
- R2: Lane PHY i uses control bits `dsi_ctl[3i+2:3i]`: bit 0 is the gate, bit 1 is the low-power regulator and bit 2 is the high-power regulator. Enabling lane i drives 3'b001 one cycle before 3'b101, so the high-power regulator never rises without the gate already set.
- R3: Disabling a lane PHY drives 3'b001 (regulators off, gate kept) one cycle before 3'b000.
- R4: The camera-transmit port uses `ctx_ctl` with bit 0 as the gate and bit 1 as the regulator. Enabling it gives 2'b01 and then 2'b11. Disabling it gives 2'b01 and then 2'b00.
- R5: The USB gate `usb_gate` is set by its enable series and cleared by its disable series, each in a single update.
- R6: The HDMI enable series sets `hdmi_rst_drv`, then sets `hdmi_gate`, then clears `hdmi_ldo_pd`, one update per cycle. It then holds reset-drive high for SETTLE_US microseconds of clock cycles before clearing it in one further cycle.
- R7: The HDMI disable series sets `hdmi_ldo_pd` one cycle before it clears `hdmi_gate`.
- R8: `busy` rises one cycle after a request differs from the PHY's state and stays high until the final update. `done` is a single-cycle pulse in the cycle of the final update, with `busy` low.
- R9: A request that changes while a series runs does not alter that PHY's outputs until the running series has finished.
- R10: When several PHYs are pending at once, the lowest index is served first. Lanes are 0..NDSI-1, then camera-transmit, then USB, then HDMI.
- R11: A request equal to the PHY's current state starts nothing: `busy` stays low and all control outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timebase of the settling wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | NDSI+3 | Requested power state per PHY, 1 = on |
| dsi_ctl | output | 3*NDSI | Lane PHY control bits, three per lane |
| ctx_ctl | output | 2 | Camera-transmit regulator and gate |
| usb_gate | output | 1 | USB power gate enable |
| hdmi_rst_drv | output | 1 | HDMI reset-drive |
| hdmi_ldo_pd | output | 1 | HDMI regulator power-down |
| hdmi_gate | output | 1 | HDMI gate enable |
| busy | output | 1 | A series is running |
| done | output | 1 | One-cycle pulse at the end of a series |

## Verification
The embedded properties check ordering only: a regulator bit rises only after its gate, a gate falls only after the regulator is powered down, and reset-drive is released only with the gate up and the regulator powered. They assume `pwr_req` is synchronous to `clk` and that reset is held for at least one edge. The stimulus changes requests only on falling edges. It also raises some requests while the long HDMI settling wait is running, to exercise the held-request path.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int NDSI      = 2,
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDSI+2:0]   pwr_req,
  output logic [3*NDSI-1:0] dsi_ctl,
  output logic [1:0]        ctx_ctl,
  output logic              usb_gate,
  output logic              hdmi_rst_drv,
  output logic              hdmi_ldo_pd,
  output logic              hdmi_gate,
  output logic              busy,
  output logic              done
);
  localparam int NPHY   = NDSI + 3;
  localparam int IW     = $clog2(NPHY);
  localparam int SETTLE = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int CW     = $clog2(SETTLE + 1);
  localparam logic [IW-1:0] I_CTX  = IW'(NDSI);
  localparam logic [IW-1:0] I_USB  = IW'(NDSI + 1);
  localparam logic [IW-1:0] I_HDMI = IW'(NDSI + 2);

  logic [2:0]      dsi_q [NDSI];
  logic [NPHY-1:0] on_q;
  logic [IW-1:0]   sel_q, pick;
  logic            dir_q, found, last;
  logic [2:0]      step_q;
  logic [CW-1:0]   cnt_q;
  logic [NPHY-1:0] pend;

  assign pend = pwr_req ^ on_q;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NPHY - 1; i >= 0; i--)
      if (pend[i]) begin
        pick  = IW'(i);
        found = 1'b1;
      end
  end

  always_comb begin
    if (sel_q == I_USB)       last = (step_q == 3'd0);
    else if (sel_q == I_HDMI) last = dir_q ? (step_q == 3'd4) : (step_q == 3'd1);
    else                      last = (step_q == 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDSI; i++) dsi_q[i] <= 3'b000;
      ctx_ctl      <= 2'b00;
      usb_gate     <= 1'b0;
      hdmi_rst_drv <= 1'b0;
      hdmi_ldo_pd  <= 1'b1;
      hdmi_gate    <= 1'b0;
      on_q         <= '0;
      sel_q        <= '0;
      dir_q        <= 1'b0;
      step_q       <= 3'd0;
      cnt_q        <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (found) begin
          busy   <= 1'b1;
          sel_q  <= pick;
          dir_q  <= pwr_req[pick];
          step_q <= 3'd0;
          cnt_q  <= '0;
        end
      end else begin
        if (sel_q < I_CTX) begin
          for (int i = 0; i < NDSI; i++)
            if (sel_q == IW'(i))
              dsi_q[i] <= (step_q == 3'd0) ? 3'b001 : (dir_q ? 3'b101 : 3'b000);
        end else if (sel_q == I_CTX) begin
          ctx_ctl <= (step_q == 3'd0) ? 2'b01 : (dir_q ? 2'b11 : 2'b00);
        end else if (sel_q == I_USB) begin
          usb_gate <= dir_q;
        end else if (dir_q) begin
          case (step_q)
            3'd0:    hdmi_rst_drv <= 1'b1;
            3'd1:    hdmi_gate    <= 1'b1;
            3'd2:    hdmi_ldo_pd  <= 1'b0;
            3'd4:    hdmi_rst_drv <= 1'b0;
            default: ;
          endcase
        end else begin
          if (step_q == 3'd0) hdmi_ldo_pd <= 1'b1;
          else                hdmi_gate   <= 1'b0;
        end

        if (sel_q == I_HDMI && dir_q && step_q == 3'd3) begin
          if (cnt_q == CW'(SETTLE - 1)) step_q <= 3'd4;
          else                          cnt_q  <= cnt_q + 1'b1;
        end else begin
          step_q <= step_q + 3'd1;
        end

        if (last) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          on_q[sel_q] <= dir_q;
        end
      end
    end
  end

  for (genvar g = 0; g < NDSI; g++) begin : g_dsi
    assign dsi_ctl[3*g +: 3] = dsi_q[g];

    // R2
    dsi_hp_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsi_q[g][2]) |-> $past(dsi_q[g][0]));

    // R3
    dsi_gate_after_ldo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dsi_q[g][0]) |-> $past(dsi_q[g][2:1]) == 2'b00);
  end

  // R4
  ctx_ldo_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_ctl[1]) |-> $past(ctx_ctl[0]));

  // R6
  hdmi_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hdmi_rst_drv) |-> (hdmi_gate && !hdmi_ldo_pd));

  // R7
  hdmi_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hdmi_gate) |-> $past(hdmi_ldo_pd));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R9
  one_phy_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dsi_ctl) && $stable(ctx_ctl) && $stable(usb_gate) &&
              $stable(hdmi_gate) && $stable(hdmi_ldo_pd) && $stable(hdmi_rst_drv));
endmodule

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;
  localparam int NDSI = 2;
  localparam int NPHY = NDSI + 3;
  localparam int S    = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPHY-1:0] req = '0;
  logic [3*NDSI-1:0] dsi_ctl;
  logic [1:0] ctx_ctl;
  logic usb_gate, hdmi_rst_drv, hdmi_ldo_pd, hdmi_gate, busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  phy_pwr_seq #(.NDSI(NDSI)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_req(req), .dsi_ctl(dsi_ctl), .ctx_ctl(ctx_ctl),
    .usb_gate(usb_gate), .hdmi_rst_drv(hdmi_rst_drv), .hdmi_ldo_pd(hdmi_ldo_pd),
    .hdmi_gate(hdmi_gate), .busy(busy), .done(done));

  // {phy[2:0], dir, two_step, first[2:0], final[2:0]}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 1'b1, 1'b1, 3'b001, 3'b101},
    {3'd1, 1'b1, 1'b1, 3'b001, 3'b101},
    {3'd2, 1'b1, 1'b1, 3'b001, 3'b011},
    {3'd3, 1'b1, 1'b0, 3'b001, 3'b001},
    {3'd0, 1'b0, 1'b1, 3'b001, 3'b000},
    {3'd2, 1'b0, 1'b1, 3'b001, 3'b000},
    {3'd3, 1'b0, 1'b0, 3'b000, 3'b000},
    {3'd1, 1'b0, 1'b1, 3'b001, 3'b000}};

  function automatic logic [2:0] ctl(int i);
    if (i < NDSI)          return dsi_ctl[3*i +: 3];
    else if (i == NDSI)    return {1'b0, ctx_ctl};
    else if (i == NDSI+1)  return {2'b00, usb_gate};
    else                   return {hdmi_rst_drv, hdmi_ldo_pd, hdmi_gate};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk("R1 dsi", dsi_ctl, 0);
    chk("R1 ctx/usb", {ctx_ctl, usb_gate}, 0);
    chk("R1 hdmi", {hdmi_rst_drv, hdmi_ldo_pd, hdmi_gate}, 3'b010);
    chk("R1 busy/done", {busy, done}, 0);

    for (int v = 0; v < 8; v++) begin
      automatic int ph = int'(VEC[v][10:8]);
      automatic string tg = (ph < NDSI) ? (VEC[v][7] ? "R2" : "R3") : (ph == NDSI) ? "R4" : "R5";
      req[ph] = VEC[v][7];
      tick(1);
      chk("R8 busy rise", busy, 1);
      tick(1);
      chk(tg, ctl(ph), VEC[v][5:3]);
      if (VEC[v][6]) begin
        tick(1);
        chk(tg, ctl(ph), VEC[v][2:0]);
      end
      chk("R8 done at end", {busy, done}, 2'b01);
      tick(1);
      chk("R8 done pulse", done, 0);
    end

    // R11: requests equal to state
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk("R11 idle", {busy, dsi_ctl, ctx_ctl, usb_gate, hdmi_rst_drv, hdmi_ldo_pd, hdmi_gate}, 12'b000000000010);
    end

    // R10 priority
    req[1] = 1'b1; req[3] = 1'b1;
    tick(3);
    chk("R10 lane first", {ctl(1), usb_gate}, 4'b1010);
    tick(2);
    chk("R10 usb next", {usb_gate, done}, 2'b11);

    // R6 with held request R9
    req[4] = 1'b1;
    tick(2);
    chk("R6 rst first", ctl(4), 3'b110);
    tick(1);
    chk("R6 gate", ctl(4), 3'b111);
    tick(1);
    chk("R6 ldo up", ctl(4), 3'b101);
    req[0] = 1'b1;
    tick(S);
    chk("R6 still settling", {ctl(4), busy}, 4'b1011);
    chk("R9 held", ctl(0), 3'b000);
    tick(1);
    chk("R6 rst released", {ctl(4), done}, 4'b0011);
    chk("R9 held at done", ctl(0), 3'b000);
    tick(1);
    chk("R9 served", busy, 1);
    tick(2);
    chk("R9 lane on", ctl(0), 3'b101);

    // R7
    req[4] = 1'b0;
    tick(2);
    chk("R7 pd first", ctl(4), 3'b011);
    tick(1);
    chk("R7 gate off", {ctl(4), done}, 4'b0101);

    tick(2);
    summary();
  end
endmodule